// File: doc/BRIEF.md
# SOF Frame Number and Time Tracker

This block builds a 32-bit status word from the start-of-frame tokens a USB device receives. The token decoder upstream gives it a one-cycle strobe for each valid SOF and the 11-bit frame number that SOF carries. The block keeps the most recent frame number.

It also counts how many SOFs in a row repeated that number. In high-speed operation the host sends eight microframe SOFs with the same frame number, so software can read this count to find the current microframe index.

A sub-frame timer measures the time since the last SOF in 0.5 µs ticks. The timer is derived from the 60 MHz link clock, and software reads it to judge where the bus is inside the current (micro)frame. The word is plain state: a register interface elsewhere reads it.

Top module: `sof_frame_tracker`

## Requirements
- R1: While reset is held, and after it is released, the whole status word reads zero until the first clock edge changes a field.
- R2: The cycle after a strobe, bits 26:16 hold the frame number sampled with that strobe.
- R3: The first SOF after reset sets the repeat count in bits 31:28 to zero, whatever its frame number.
- R4: An SOF whose frame number differs from the held number sets the repeat count to zero.
- R5: An SOF whose frame number equals the held number adds one to the repeat count. The count saturates at 15.
- R6: The timer in bits 11:0 advances by one every 30 clock cycles, which is 0.5 µs at 60 MHz.
- R7: The timer saturates at 0xFFF and does not wrap.
- R8: Every SOF clears the timer and its 30-cycle prescaler. The timer then reads 0 for the next 29 cycles and 1 on the 30th cycle.
- R9: Bits 27 and 15:12 always read zero.
- R10: Without a strobe, bits 31:16 do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 60 MHz link clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sof_valid | input | 1 | One-cycle strobe for each valid SOF token |
| sof_frame | input | 11 | Frame number carried by the SOF |
| status_word | output | 32 | Repeat count, frame number and sub-frame time |

## Verification
Two functions can fall in the same cycle. An SOF strobe can arrive on the same edge at which the prescaler reaches its last count and would advance the timer, and it can arrive while the repeat count is already saturated. The bench places strobes exactly on a prescaler wrap, halfway through a prescaler period, and after sixteen or more repeats of one number. A scoreboard predicts each word from the requirements: the clear must win over the tick, the count must hold at 15, and the timer must restart a full 30-cycle period after the strobe.

// File: rtl/sof_trk_pkg.sv
package sof_trk_pkg;
   localparam int FRAME_W   = 11;
   localparam int RPT_W     = 4;
   localparam int TIME_W    = 12;
   localparam int WORD_W    = 32;
   localparam int TIME_LSB  = 0;
   localparam int FRAME_LSB = 16;
   localparam int RPT_LSB   = 28;
   localparam int TICK_DIV  = 30;
endpackage

// File: rtl/frame_repeat_counter.sv
module frame_repeat_counter #(
   parameter int FRAME_W = 11,
   parameter int RPT_W   = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               sof_valid,
   input  logic [FRAME_W-1:0] sof_frame,
   output logic [FRAME_W-1:0] frame_q,
   output logic [RPT_W-1:0]   rpt_q
);
   localparam logic [RPT_W-1:0] RPT_MAX = {RPT_W{1'b1}};

   logic seen_q;
   logic same_num;

   assign same_num = seen_q && (sof_frame == frame_q);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         frame_q <= '0;
         rpt_q   <= '0;
         seen_q  <= 1'b0;
      end else if (sof_valid) begin
         frame_q <= sof_frame;
         seen_q  <= 1'b1;
         if (!same_num)
            rpt_q <= '0;
         else if (rpt_q != RPT_MAX)
            rpt_q <= rpt_q + 1'b1;
      end
   end
endmodule

// File: rtl/subframe_timer.sv
module subframe_timer #(
   parameter int TIME_W   = 12,
   parameter int TICK_DIV = 30
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear,
   output logic [TIME_W-1:0] time_q
);
   localparam logic [TIME_W-1:0] TIME_MAX = {TIME_W{1'b1}};

   logic tick;

   generate
      if (TICK_DIV < 1) begin : g_bad_div
         $error("subframe_timer: TICK_DIV must be at least 1");
      end
      if (TICK_DIV == 1) begin : g_no_pre
         assign tick = !clear;
      end else begin : g_pre
         localparam int PRE_W = $clog2(TICK_DIV);
         localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(TICK_DIV - 1);
         logic [PRE_W-1:0] pre_q;

         always_ff @(posedge clk) begin
            if (!rst_n || clear)
               pre_q <= '0;
            else if (pre_q == PRE_LAST)
               pre_q <= '0;
            else
               pre_q <= pre_q + 1'b1;
         end

         assign tick = !clear && (pre_q == PRE_LAST);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n || clear)
         time_q <= '0;
      else if (tick && time_q != TIME_MAX)
         time_q <= time_q + 1'b1;
   end
endmodule

// File: rtl/sof_frame_tracker.sv
module sof_frame_tracker
   import sof_trk_pkg::*;
#(
   parameter int P_FRAME_W   = FRAME_W,
   parameter int P_RPT_W     = RPT_W,
   parameter int P_TIME_W    = TIME_W,
   parameter int P_WORD_W    = WORD_W,
   parameter int P_FRAME_LSB = FRAME_LSB,
   parameter int P_RPT_LSB   = RPT_LSB,
   parameter int P_TICK_DIV  = TICK_DIV
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 sof_valid,
   input  logic [P_FRAME_W-1:0] sof_frame,
   output logic [P_WORD_W-1:0]  status_word
);
   generate
      if (P_TIME_W > P_FRAME_LSB) begin : g_bad_time
         $error("sof_frame_tracker: timer field overlaps frame field");
      end
      if (P_FRAME_LSB + P_FRAME_W > P_RPT_LSB) begin : g_bad_frame
         $error("sof_frame_tracker: frame field overlaps repeat field");
      end
      if (P_RPT_LSB + P_RPT_W > P_WORD_W) begin : g_bad_rpt
         $error("sof_frame_tracker: repeat field exceeds word");
      end
   endgenerate

   logic [P_FRAME_W-1:0] frame_q;
   logic [P_RPT_W-1:0]   rpt_q;
   logic [P_TIME_W-1:0]  time_q;

   frame_repeat_counter #(
      .FRAME_W (P_FRAME_W),
      .RPT_W   (P_RPT_W)
   ) u_rpt (
      .clk       (clk),
      .rst_n     (rst_n),
      .sof_valid (sof_valid),
      .sof_frame (sof_frame),
      .frame_q   (frame_q),
      .rpt_q     (rpt_q)
   );

   subframe_timer #(
      .TIME_W   (P_TIME_W),
      .TICK_DIV (P_TICK_DIV)
   ) u_tmr (
      .clk    (clk),
      .rst_n  (rst_n),
      .clear  (sof_valid),
      .time_q (time_q)
   );

   always_comb begin
      status_word = '0;
      status_word[P_TIME_W-1:0]             = time_q;
      status_word[P_FRAME_LSB +: P_FRAME_W] = frame_q;
      status_word[P_RPT_LSB +: P_RPT_W]     = rpt_q;
   end
endmodule

// File: rtl/sof_tracker_chk.sv
module sof_tracker_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        sof_valid,
   input logic [10:0] sof_frame,
   input logic [31:0] status_word
);
   logic [11:0] tm;
   logic [10:0] fr;
   logic [3:0]  rc;
   assign tm = status_word[11:0];
   assign fr = status_word[26:16];
   assign rc = status_word[31:28];

   // R2
   frame_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sof_valid |=> fr == $past(sof_frame));

   // R4
   new_number_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sof_valid && sof_frame != fr) |=> rc == 4'd0);

   // R5
   rpt_hold_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sof_valid && sof_frame == fr && rc == 4'hF) |=> rc == 4'hF);

   // R8
   sof_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sof_valid |=> tm == 12'd0);

   // R6
   timer_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!sof_valid && tm != 12'hFFF) |=> (tm == $past(tm) || tm == $past(tm) + 12'd1));

   // R7
   timer_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!sof_valid && tm == 12'hFFF) |=> tm == 12'hFFF);

   // R9
   reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      status_word[27] == 1'b0 && status_word[15:12] == 4'd0);

   // R10
   upper_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !sof_valid |=> $stable(status_word[31:16]));
endmodule

bind sof_frame_tracker sof_tracker_chk u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .sof_valid   (sof_valid),
   .sof_frame   (sof_frame),
   .status_word (status_word)
);

// File: tb/sof_frame_tracker_test.sv
module sof_frame_tracker_test;
   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 190000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sof_valid = 1'b0;
   logic [10:0] sof_frame = '0;
   logic [31:0] status_word;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   logic [31:0] exp_q[$];

   // requirement model
   bit          m_seen = 0;
   logic [10:0] m_frame = '0;
   int          m_rpt = 0;
   int          m_since = 0;

   sof_frame_tracker uut (
      .clk         (clk),
      .rst_n       (rst_n),
      .sof_valid   (sof_valid),
      .sof_frame   (sof_frame),
      .status_word (status_word)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic step(input bit s, input logic [10:0] f);
      logic [31:0] w;
      int t;
      @(negedge clk);
      sof_valid = s;
      sof_frame = f;
      if (s) begin
         if (m_seen && f == m_frame) begin
            if (m_rpt < 15) m_rpt++;
         end else begin
            m_rpt = 0;
         end
         m_frame = f;
         m_seen  = 1;
         m_since = 0;
      end else begin
         m_since++;
      end
      t = m_since / 30;
      if (t > 4095) t = 4095;
      w = '0;
      w[11:0]  = t[11:0];
      w[26:16] = m_frame;
      w[31:28] = m_rpt[3:0];
      exp_q.push_back(w);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) step(1'b0, sof_frame);
   endtask

   // monitor: compares each field one cycle after the edge that produced it
   always @(posedge clk) begin
      #1;
      if (exp_q.size() > 0) begin
         logic [31:0] e;
         e = exp_q.pop_front();
         chk("R2 frame",           {21'd0, status_word[26:16]}, {21'd0, e[26:16]});
         chk("R3 R4 R5 repeat",    {28'd0, status_word[31:28]}, {28'd0, e[31:28]});
         chk("R6 R7 R8 timer",     {20'd0, status_word[11:0]},  {20'd0, e[11:0]});
         chk("R9 reserved",        {27'd0, status_word[27], status_word[15:12]}, 32'd0);
      end
   end

   initial begin
      int cyc = 0;
      while (!done) begin
         @(posedge clk);
         cyc++;
         if (cyc > WATCHDOG) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=<%0d", cyc, WATCHDOG);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
         end
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      // R1: reset state
      chk("R1 reset", status_word, 32'd0);
      @(negedge clk);
      rst_n = 1'b1;
      // R1: first cycle after release, only timer prescaler moves
      step(1'b0, 11'd0);
      // R3: first SOF after reset, frame 0 matches reset value yet count is 0
      step(1'b1, 11'd0);
      // R5: repeats count up
      step(1'b1, 11'd0);
      step(1'b1, 11'd0);
      step(1'b1, 11'd0);
      // R6 and R10: two ticks, upper fields held
      idle(65);
      // R4 and R8: new number clears count and timer
      step(1'b1, 11'h7FF);
      // R5: saturate the repeat count at 15
      for (int i = 0; i < 20; i++) step(1'b1, 11'h7FF);
      // R8: SOF on the exact cycle the prescaler wraps
      idle(29);
      step(1'b1, 11'h7FF);
      idle(31);
      // R8: SOF halfway through a prescaler period, then boundary 29/30
      idle(15);
      step(1'b1, 11'h123);
      idle(29);
      idle(2);
      // R4: different number resets a nonzero count
      step(1'b1, 11'h124);
      step(1'b1, 11'h124);
      step(1'b1, 11'h125);
      // R7: run the timer into saturation and keep it there
      idle(4095 * 30 + 200);
      step(1'b1, 11'h001);
      idle(5);
      sof_valid = 1'b0;
      while (exp_q.size() > 0) @(negedge clk);
      @(negedge clk);
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule